// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A test clock and a mode-select line walk a sixteen-state controller. A serial data input and a serial data output carry instructions and data. A four-bit instruction register picks which data path sits between the serial input and the serial output:

- a one-stage bypass stage;
- a 32-bit identification word;
- an external boundary chain. The chain is reached through capture, shift and update strobes, and it returns its data on `chain_so`.

The instruction decoder also drives three pin controls. One places the pins under test control. One forces every chip output driver to high impedance. One flags that the bypass stage is selected. Besides the three mandatory instructions and the identification read, the decoder has two extra codes. Both select the bypass stage: one forces all outputs to high impedance, and the other drives the pins from the values held in the boundary chain. The identification instruction becomes current after an asynchronous hardware reset and after any pass through Test-Logic-Reset.

Controller states, with the next state for mode-select 0 / 1:

| State | Next on 0 | Next on 1 |
|---|---|---|
| Test-Logic-Reset | Run-Test/Idle | Test-Logic-Reset |
| Run-Test/Idle | Run-Test/Idle | Select-DR |
| Select-DR | Capture-DR | Select-IR |
| Capture-DR | Shift-DR | Exit1-DR |
| Shift-DR | Shift-DR | Exit1-DR |
| Exit1-DR | Pause-DR | Update-DR |
| Pause-DR | Pause-DR | Exit2-DR |
| Exit2-DR | Shift-DR | Update-DR |
| Update-DR | Run-Test/Idle | Select-DR |
| Select-IR | Capture-IR | Test-Logic-Reset |

Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR follow the same transitions as their DR counterparts.

Top module: `scan_tap_ctrl`

## Requirements
- R1: The controller follows the sixteen-state graph above on each rising edge of `scan_clk`. It enters Test-Logic-Reset while `rst_n` is low, and again after five consecutive rising edges with `scan_mode` high, from any state. A DR scan may pass through Pause-DR and Exit2-DR and resume shifting without losing bits.
- R2: After a hardware reset, or after the controller passes through Test-Logic-Reset, the current instruction is the identification read (code 0001). A DR scan then returns the identification word, and all three pin controls are low.
- R3: Capture-IR loads 0001 into the instruction shift stage. That stage shifts LSB first, so the first four bits out during Shift-IR are 1, 0, 0, 0.
- R4: A shifted instruction code takes effect only on the rising edge that leaves Update-IR. The pin controls and the data path stay unchanged while the controller is in Shift-IR, Exit1-IR and Update-IR.
- R5: Codes 0000 (external test) and 0010 (sample) select the external chain. Code 0001 selects the identification word. Codes 0011 (force high-Z), 0100 (hold pins) and 1111 (bypass), and every other code, select the bypass stage, and `bypass_sel` is high for exactly those codes.
- R6: `pin_test_mode` is high for codes 0000 and 0100 only.
- R7: `pin_force_hiz` is high for code 0011 only.
- R8: The bypass stage captures 0 in Capture-DR and delays the serial input by one stage. A 32-bit scan with input word P returns {P[30:0], 0}.
- R9: The identification word is {version[3:0], part[15:0], maker[10:0], 1}. It defaults to 0x10003003 and shifts out LSB first.
- R10: `scan_dout` changes only on the falling edge of `scan_clk`. `scan_dout_oe` is high only while the controller is in Shift-IR or Shift-DR, and low otherwise.
- R11: `chain_capture`, `chain_shift` and `chain_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and only while the external chain is selected. While it is selected, `chain_so` is returned on `scan_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| scan_mode | input | 1 | Mode select, sampled on the rising edge |
| scan_din | input | 1 | Serial data input, LSB first |
| scan_dout | output | 1 | Serial data output, updated on the falling edge |
| scan_dout_oe | output | 1 | Output enable for the serial output pad |
| chain_so | input | 1 | Serial return from the external boundary chain |
| chain_capture | output | 1 | Boundary chain capture strobe |
| chain_shift | output | 1 | Boundary chain shift strobe |
| chain_update | output | 1 | Boundary chain update strobe |
| pin_test_mode | output | 1 | Pins driven from the boundary chain |
| pin_force_hiz | output | 1 | All chip output drivers disabled |
| bypass_sel | output | 1 | Bypass stage is the selected data path |

## Verification
The hardest condition to reach from the ports is a DR scan that is interrupted in Pause-DR and then resumed through Exit2-DR. Only a precise mode-select sequence in the middle of a shift gets there. The bench shifts eight identification bits, parks the controller in Pause-DR for two cycles, returns to Shift-DR through Exit2-DR, and checks that the remaining 24 bits continue the word with no gap. The bench also stops an instruction load at Exit1-IR and at Update-IR to show that the pin controls have not yet moved. It then takes one more edge to show that they have.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SHIFT_DR,
        ST_EXIT1_DR,
        ST_PAUSE_DR,
        ST_EXIT2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SHIFT_IR,
        ST_EXIT1_IR,
        ST_PAUSE_IR,
        ST_EXIT2_IR,
        ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_CHAIN,
        SEL_ID,
        SEL_BYP
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_EXTEST    = 4'b0000;
    localparam logic [IR_W-1:0] OP_IDREAD    = 4'b0001;
    localparam logic [IR_W-1:0] OP_SAMPLE    = 4'b0010;
    localparam logic [IR_W-1:0] OP_FORCE_HIZ = 4'b0011;
    localparam logic [IR_W-1:0] OP_HOLD_PINS = 4'b0100;
    localparam logic [IR_W-1:0] OP_BYPASS    = 4'b1111;

    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e next_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_RESET:    next_state = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     next_state = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   next_state = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   next_state = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: next_state = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: next_state = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: next_state = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: next_state = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   next_state = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   next_state = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   next_state = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: next_state = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: next_state = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: next_state = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: next_state = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   next_state = tms ? ST_SEL_DR   : ST_IDLE;
            default:     next_state = ST_RESET;
        endcase
    end

    // Checker: run length of consecutive mode-select ones, saturating at 5.
    logic [2:0] ones_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             ones_run <= 3'd0;
        else if (!tms)          ones_run <= 3'd0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    a_r1_five_ones_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_run == 3'd5) |-> (state == ST_RESET));

    a_r1_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

    a_r1_pause_to_exit2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE_DR && tms) |=> (state == ST_EXIT2_DR));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       ir_lsb,
    output dr_sel_e    dr_sel,
    output logic       test_mode,
    output logic       force_hiz
);

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] instr;

    // Instruction shift stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_sh <= IR_CAPTURE_PAT;
        end else begin
            unique case (state)
                ST_CAP_IR:   ir_sh <= IR_CAPTURE_PAT;
                ST_SHIFT_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                default:     ir_sh <= ir_sh;
            endcase
        end
    end

    // Current instruction: changes only at Update-IR or in Test-Logic-Reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr <= OP_IDREAD;
        end else begin
            unique case (state)
                ST_RESET:  instr <= OP_IDREAD;
                ST_UPD_IR: instr <= ir_sh;
                default:   instr <= instr;
            endcase
        end
    end

    assign ir_lsb = ir_sh[0];

    // Decode: data path and pin controls.
    always_comb begin
        dr_sel    = SEL_BYP;
        test_mode = 1'b0;
        force_hiz = 1'b0;
        unique case (instr)
            OP_EXTEST: begin
                dr_sel    = SEL_CHAIN;
                test_mode = 1'b1;
            end
            OP_IDREAD:    dr_sel = SEL_ID;
            OP_SAMPLE:    dr_sel = SEL_CHAIN;
            OP_FORCE_HIZ: force_hiz = 1'b1;
            OP_HOLD_PINS: test_mode = 1'b1;
            default:      dr_sel = SEL_BYP;
        endcase
    end

    a_r3_capture_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAP_IR) |=> (ir_sh == IR_CAPTURE_PAT));

    a_r4_instr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(instr));

    a_r2_reset_idread: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET) |=> (dr_sel == SEL_ID && !test_mode && !force_hiz));

    a_r7_hiz_on_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        force_hiz |-> (dr_sel == SEL_BYP && !test_mode));

    a_r6_test_not_id: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (dr_sel != SEL_ID));

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION = 4'h1,
    parameter logic [15:0] ID_PART    = 16'h0003,
    parameter logic [10:0] ID_MAKER   = 11'd1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  tap_state_e state,
    input  dr_sel_e    dr_sel,
    input  logic       tdi,
    input  logic       ir_lsb,
    input  logic       chain_so,
    output logic       chain_capture,
    output logic       chain_shift,
    output logic       chain_update,
    output logic       tdo,
    output logic       tdo_oe
);

    localparam int          ID_W   = 4 + 16 + 11 + 1;
    localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

    logic            byp_q;
    logic [ID_W-1:0] id_sh;
    logic            dr_lsb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
        end else if (dr_sel == SEL_BYP) begin
            unique case (state)
                ST_CAP_DR:   byp_q <= 1'b0;
                ST_SHIFT_DR: byp_q <= tdi;
                default:     byp_q <= byp_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_sh <= ID_WORD;
        end else if (dr_sel == SEL_ID) begin
            unique case (state)
                ST_CAP_DR:   id_sh <= ID_WORD;
                ST_SHIFT_DR: id_sh <= {tdi, id_sh[ID_W-1:1]};
                default:     id_sh <= id_sh;
            endcase
        end
    end

    always_comb begin
        unique case (dr_sel)
            SEL_CHAIN: dr_lsb = chain_so;
            SEL_ID:    dr_lsb = id_sh[0];
            default:   dr_lsb = byp_q;
        endcase
    end

    assign chain_capture = (dr_sel == SEL_CHAIN) && (state == ST_CAP_DR);
    assign chain_shift   = (dr_sel == SEL_CHAIN) && (state == ST_SHIFT_DR);
    assign chain_update  = (dr_sel == SEL_CHAIN) && (state == ST_UPD_DR);

    // Serial output stage, retimed to the falling edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (state == ST_SHIFT_DR) || (state == ST_SHIFT_IR);
            if (state == ST_SHIFT_IR)      tdo <= ir_lsb;
            else if (state == ST_SHIFT_DR) tdo <= dr_lsb;
            else                           tdo <= 1'b0;
        end
    end

    a_r8_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAP_DR && dr_sel == SEL_BYP) |=> (byp_q == 1'b0));

    a_r9_id_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAP_DR && dr_sel == SEL_ID) |=> (id_sh == ID_WORD));

    a_r10_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
        tdo_oe |-> (state == ST_SHIFT_DR || state == ST_SHIFT_IR));

    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chain_capture, chain_shift, chain_update}));

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION = 4'h1,
    parameter logic [15:0] ID_PART    = 16'h0003,
    parameter logic [10:0] ID_MAKER   = 11'd1
) (
    input  logic scan_clk,
    input  logic rst_n,
    input  logic scan_mode,
    input  logic scan_din,
    output logic scan_dout,
    output logic scan_dout_oe,
    input  logic chain_so,
    output logic chain_capture,
    output logic chain_shift,
    output logic chain_update,
    output logic pin_test_mode,
    output logic pin_force_hiz,
    output logic bypass_sel
);

    tap_state_e state;
    dr_sel_e    dr_sel;
    logic       ir_lsb;

    scan_tap_fsm u_fsm (
        .clk   (scan_clk),
        .rst_n (rst_n),
        .tms   (scan_mode),
        .state (state)
    );

    scan_tap_ir u_ir (
        .clk       (scan_clk),
        .rst_n     (rst_n),
        .state     (state),
        .tdi       (scan_din),
        .ir_lsb    (ir_lsb),
        .dr_sel    (dr_sel),
        .test_mode (pin_test_mode),
        .force_hiz (pin_force_hiz)
    );

    scan_tap_dr #(
        .ID_VERSION (ID_VERSION),
        .ID_PART    (ID_PART),
        .ID_MAKER   (ID_MAKER)
    ) u_dr (
        .clk           (scan_clk),
        .rst_n         (rst_n),
        .state         (state),
        .dr_sel        (dr_sel),
        .tdi           (scan_din),
        .ir_lsb        (ir_lsb),
        .chain_so      (chain_so),
        .chain_capture (chain_capture),
        .chain_shift   (chain_shift),
        .chain_update  (chain_update),
        .tdo           (scan_dout),
        .tdo_oe        (scan_dout_oe)
    );

    assign bypass_sel = (dr_sel == SEL_BYP);

    a_r5_bypass_no_strobe: assert property (@(posedge scan_clk) disable iff (!rst_n)
        bypass_sel |-> !(chain_capture || chain_shift || chain_update));

endmodule

// File: tb/test_scan_tap_ctrl.sv
module test_scan_tap_ctrl;

    logic scan_clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_mode = 1'b1;
    logic scan_din = 1'b0;
    logic scan_dout, scan_dout_oe;
    logic chain_so;
    logic chain_capture, chain_shift, chain_update;
    logic pin_test_mode, pin_force_hiz, bypass_sel;

    always #10 scan_clk = ~scan_clk;

    scan_tap_ctrl i_scan_tap_ctrl (
        .scan_clk      (scan_clk),
        .rst_n         (rst_n),
        .scan_mode     (scan_mode),
        .scan_din      (scan_din),
        .scan_dout     (scan_dout),
        .scan_dout_oe  (scan_dout_oe),
        .chain_so      (chain_so),
        .chain_capture (chain_capture),
        .chain_shift   (chain_shift),
        .chain_update  (chain_update),
        .pin_test_mode (pin_test_mode),
        .pin_force_hiz (pin_force_hiz),
        .bypass_sel    (bypass_sel)
    );

    // Bench model of an 8-cell external boundary chain.
    localparam logic [7:0]  CHAIN_CAP = 8'hC3;
    localparam logic [31:0] ID_EXP    = {4'h1, 16'h0003, 11'd1, 1'b1};
    logic [7:0] chain_q = 8'h00;
    int cap_cnt = 0;
    int upd_cnt = 0;
    assign chain_so = chain_q[0];
    always @(posedge scan_clk) begin
        if (chain_capture)    chain_q <= CHAIN_CAP;
        else if (chain_shift) chain_q <= {scan_din, chain_q[7:1]};
        if (chain_capture) cap_cnt <= cap_cnt + 1;
        if (chain_update)  upd_cnt <= upd_cnt + 1;
    end

    int n_cmp = 0;
    int n_bad = 0;
    logic last_oe;
    logic hold_ok;
    logic oe_ok;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One test-clock cycle: drive after the falling edge, sample the serial
    // output before the rising edge and again just after it.
    task automatic step(input logic tms, input logic tdi, output logic tdo);
        logic held;
        @(negedge scan_clk);
        #2;
        scan_mode = tms;
        scan_din  = tdi;
        #3;
        tdo     = scan_dout;
        last_oe = scan_dout_oe;
        @(posedge scan_clk);
        #1;
        held = scan_dout;
        if (held !== tdo) hold_ok = 1'b0;
    endtask

    task automatic load_ir(input logic [3:0] code, output logic [3:0] cap);
        logic b;
        step(1'b1, 1'b0, b);
        step(1'b1, 1'b0, b);
        step(1'b0, 1'b0, b);
        step(1'b0, 1'b0, b);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, code[i], b);
            cap[i] = b;
        end
        step(1'b1, 1'b0, b);
        step(1'b0, 1'b0, b);
    endtask

    task automatic scan_dr(input logic [31:0] din, output logic [31:0] dout);
        logic b;
        step(1'b1, 1'b0, b);
        step(1'b0, 1'b0, b);
        step(1'b0, 1'b0, b);
        oe_ok = 1'b1;
        for (int i = 0; i < 32; i++) begin
            step(i == 31, din[i], b);
            dout[i] = b;
            if (last_oe !== 1'b1) oe_ok = 1'b0;
        end
        step(1'b1, 1'b0, b);
        step(1'b0, 1'b0, b);
    endtask

    // {code[3:0], test, hiz, byp, kind[1:0]}; kind 0 chain, 1 id, 2 bypass
    localparam logic [8:0] VEC [8] = '{
        {4'b0000, 1'b1, 1'b0, 1'b0, 2'd0},
        {4'b0001, 1'b0, 1'b0, 1'b0, 2'd1},
        {4'b0010, 1'b0, 1'b0, 1'b0, 2'd0},
        {4'b0011, 1'b0, 1'b1, 1'b1, 2'd2},
        {4'b0100, 1'b1, 1'b0, 1'b1, 2'd2},
        {4'b1111, 1'b0, 1'b0, 1'b1, 2'd2},
        {4'b0101, 1'b0, 1'b0, 1'b1, 2'd2},
        {4'b1010, 1'b0, 1'b0, 1'b1, 2'd2}
    };
    localparam logic [31:0] PAT = 32'hA5C3_0F96;

    initial begin : watchdog
        #4_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [3:0]  cap;
        logic [31:0] rd;
        logic [31:0] exp;
        logic        b;
        int          c0, u0;
        hold_ok = 1'b1;

        // Reset state (R2, R10)
        repeat (3) @(posedge scan_clk);
        #1;
        chk("R2 reset pin controls", {29'd0, pin_test_mode, pin_force_hiz, bypass_sel}, 32'd0);
        chk("R10 oe low in reset", {31'd0, scan_dout_oe}, 32'd0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, b);
        chk("R10 oe low in idle", {31'd0, last_oe}, 32'd0);
        scan_dr(PAT, rd);
        chk("R2 R9 id after hardware reset", rd, ID_EXP);
        chk("R10 oe high during shift", {31'd0, oe_ok}, 32'd1);

        // Table of instructions (R3, R5, R6, R7, R8, R9, R11)
        for (int v = 0; v < 8; v++) begin
            load_ir(VEC[v][8:5], cap);
            chk($sformatf("R3 capture pattern op=%b", VEC[v][8:5]), {28'd0, cap}, 32'h1);
            chk($sformatf("R6 test mode op=%b", VEC[v][8:5]), {31'd0, pin_test_mode}, {31'd0, VEC[v][4]});
            chk($sformatf("R7 force hiz op=%b", VEC[v][8:5]), {31'd0, pin_force_hiz}, {31'd0, VEC[v][3]});
            chk($sformatf("R5 bypass sel op=%b", VEC[v][8:5]), {31'd0, bypass_sel}, {31'd0, VEC[v][2]});
            c0 = cap_cnt;
            u0 = upd_cnt;
            scan_dr(PAT, rd);
            case (VEC[v][1:0])
                2'd0:    exp = {PAT[23:0], CHAIN_CAP};
                2'd1:    exp = ID_EXP;
                default: exp = {PAT[30:0], 1'b0};
            endcase
            chk($sformatf("R5 R8 R9 R11 dr data op=%b", VEC[v][8:5]), rd, exp);
            chk($sformatf("R11 strobe counts op=%b", VEC[v][8:5]),
                {cap_cnt - c0, upd_cnt - u0},
                (VEC[v][1:0] == 2'd0) ? {32'd1, 32'd1} : {32'd0, 32'd0});
        end

        // R4: instruction does not act before leaving Update-IR
        load_ir(4'b0001, cap);
        step(1'b1, 1'b0, b);
        step(1'b1, 1'b0, b);
        step(1'b0, 1'b0, b);
        step(1'b0, 1'b0, b);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, (4'b0011 >> i) & 1'b1, b);
            if (i < 3) chk("R4 no change in Shift-IR", {31'd0, pin_force_hiz}, 32'd0);
        end
        chk("R4 no change in Exit1-IR", {30'd0, pin_force_hiz, bypass_sel}, 32'd0);
        step(1'b1, 1'b0, b);
        chk("R4 no change in Update-IR", {30'd0, pin_force_hiz, bypass_sel}, 32'd0);
        step(1'b0, 1'b0, b);
        chk("R4 applied after Update-IR", {30'd0, pin_force_hiz, bypass_sel}, 32'd3);

        // R1 R2: five mode-select ones return to reset and the id read
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, b);
        chk("R1 R2 soft reset pins", {29'd0, pin_test_mode, pin_force_hiz, bypass_sel}, 32'd0);
        step(1'b0, 1'b0, b);
        scan_dr(32'h0, rd);
        chk("R1 R2 id after soft reset", rd, ID_EXP);

        // R1: Pause-DR and Exit2-DR resume mid-scan
        step(1'b1, 1'b0, b);
        step(1'b0, 1'b0, b);
        step(1'b0, 1'b0, b);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, 1'b0, b);
            rd[i] = b;
        end
        step(1'b0, 1'b0, b);
        step(1'b0, 1'b0, b);
        chk("R10 oe low in Pause-DR", {31'd0, last_oe}, 32'd0);
        step(1'b1, 1'b0, b);
        step(1'b0, 1'b0, b);
        for (int i = 8; i < 32; i++) begin
            step(i == 31, 1'b0, b);
            rd[i] = b;
        end
        step(1'b1, 1'b0, b);
        step(1'b0, 1'b0, b);
        chk("R1 pause-resume id word", rd, ID_EXP);

        // R1 R2: hardware reset mid-operation
        load_ir(4'b0000, cap);
        chk("R6 extest before reset", {31'd0, pin_test_mode}, 32'd1);
        @(negedge scan_clk);
        rst_n = 1'b0;
        #3;
        chk("R1 R2 async reset clears pins", {29'd0, pin_test_mode, pin_force_hiz, bypass_sel}, 32'd0);
        @(negedge scan_clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, b);
        scan_dr(PAT, rd);
        chk("R2 id after async reset", rd, ID_EXP);

        chk("R10 output changes only on falling edge", {31'd0, hold_ok}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule